// File: doc/BRIEF.md
# Parallel PRBS Pattern Generator

The block produces a pseudorandom binary sequence from a linear feedback shift register with feedback taps at the input end. On every clock cycle where the enable is high, it advances the register by `DATA_W` single-bit steps and writes the `DATA_W` bits it emitted into a registered output word. The register width, the tap polynomial, the seed and an output-complement option are all parameters. This lets one design cover the common test patterns: PRBS7 (width 7, taps 0x41), PRBS9 (0x021), PRBS15 (0x4001), PRBS23 (0x040001) and PRBS31 (0x10000001). The patterns defined as inverted (PRBS15, PRBS23, PRBS29, PRBS31) are obtained by setting the complement option.

The polynomial is given without its top term. Bit `j` of `POLY` marks a tap on the bit generated `STATE_W - j` steps earlier. Each emitted bit is the bit leaving the oldest stage, so the first `STATE_W` bits after reset are the seed itself, oldest first. The default seed is all ones. A control unit turns reset and enable into load and step strobes for a datapath that holds the register, the unrolled step logic and the output word. If a step would leave the register all zeros, the register is reseeded instead.

Top module: `prbs_gen`

## Requirements
- R1: Every generated bit is the XOR of the earlier bits selected by `POLY`. With tap bit `j` set, the bit from `STATE_W - j` steps back contributes. For PRBS7 (`POLY` = 0x41), this gives b[n] = b[n-1] XOR b[n-7].
- R2: Each enabled cycle emits the next `DATA_W` bits of the serial stream. `dataOut[0]` carries the earliest bit. The stream is the register contents leaving the oldest stage, so after reset it starts with the seed bits: seed bit `STATE_W-1` first, down to seed bit 0.
- R3: While `en` is low and `rst` is low, `dataOut` and the register state hold. The next enabled word continues the stream exactly where it stopped.
- R4: A high `rst` at a clock edge clears `dataOut` to zero and loads the seed `INIT`, whatever `en` is. The first enabled word afterwards starts the stream from the seed.
- R5: With `INVERT` set, every bit of `dataOut` is the complement of the stream bit. The register and its feedback are unaffected. This is checked with PRBS15 (width 15, `POLY` 0x4001), seed all ones, `INVERT` = 1.
- R6: If an enabled step would leave the register all zeros, the register loads `INIT` instead. The word of that step is still output. The register is never all zeros outside reset.
- R7: With the PRBS7 settings, the output stream repeats with period 127 bits and holds 64 ones in each period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high; loads the seed and clears the output |
| en | input | 1 | Advance the sequence by one word on this edge |
| dataOut | output | DATA_W | Registered word of sequence bits, earliest bit in bit 0 |

## Verification
The hardest case to reach from the ports is the all-zero reseed. With a primitive polynomial and a nonzero seed, the register can never reach zero, so the recovery path stays idle in every useful setting. The bench adds an instance with an empty polynomial and a 5-bit seed of 0b00101, emitting 3 bits per word. That register drains to zero on its second word. Because the output shows the oldest stage, the reseed is visible: the seed pattern reappears in the third word instead of a run of zeros. PRBS7 and inverted PRBS15 instances run beside it under an irregular enable pattern with a reset in the middle.

// File: rtl/prbs_pkg.sv
package prbs_pkg;

  // Strobes passed from the control unit to the datapath
  typedef struct packed {
    logic clearOut;  // force the output word to zero
    logic loadInit;  // load the seed into the register
    logic stepWord;  // advance by one word and capture it
  } prbsStrobes_t;

endpackage

// File: rtl/prbs_ctrl.sv
module prbs_ctrl
  import prbs_pkg::*;
(
  input  logic         rst,
  input  logic         en,
  input  logic         nextZero,
  output prbsStrobes_t strobes
);

  always_comb begin
    strobes.clearOut = rst;
    strobes.stepWord = en & ~rst;
    // reset reseeds; so does a step that would drain the register
    strobes.loadInit = rst | (en & nextZero);
  end

endmodule

// File: rtl/prbs_datapath.sv
module prbs_datapath
  import prbs_pkg::*;
#(
  parameter int                 STATE_W = 31,
  parameter logic [STATE_W-1:0] POLY    = 31'h10000001,
  parameter logic [STATE_W-1:0] INIT    = '1,
  parameter logic               INVERT  = 1'b1,
  parameter int                 DATA_W  = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  prbsStrobes_t        strobes,
  output logic                nextZero,
  output logic [DATA_W-1:0]   dataOut
);

  // stateQ[k] holds the bit generated k+1 steps ago; tap j reads stage STATE_W-1-j
  function automatic logic [STATE_W-1:0] mirror(input logic [STATE_W-1:0] v);
    logic [STATE_W-1:0] r;
    for (int i = 0; i < STATE_W; i++) r[i] = v[STATE_W-1-i];
    return r;
  endfunction

  localparam logic [STATE_W-1:0] TAP_MASK = mirror(POLY);

  logic [STATE_W-1:0] stateQ;
  logic [STATE_W-1:0] stateNext;
  logic [DATA_W-1:0]  wordNext;
  logic [DATA_W-1:0]  dataQ;

  // unrolled DATA_W steps; emitted bit is the oldest stage
  always_comb begin
    logic [STATE_W-1:0] walk;
    logic fb;
    walk = stateQ;
    for (int i = 0; i < DATA_W; i++) begin
      fb          = ^(walk & TAP_MASK);
      wordNext[i] = walk[STATE_W-1] ^ INVERT;
      walk        = {walk[STATE_W-2:0], fb};
    end
    stateNext = walk;
  end

  assign nextZero = (stateNext == '0);

  always_ff @(posedge clk) begin
    if (strobes.loadInit)      stateQ <= INIT;
    else if (strobes.stepWord) stateQ <= stateNext;
  end

  always_ff @(posedge clk) begin
    if (strobes.clearOut)      dataQ <= '0;
    else if (strobes.stepWord) dataQ <= wordNext;
  end

  assign dataOut = dataQ;

  // R4: reset loads the seed and clears the word
  p_reset_load_r4: assert property (@(posedge clk)
    rst |=> (dataQ == '0 && stateQ == INIT));

  // R3: no step, no change
  p_hold_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !strobes.stepWord |=> ($stable(dataQ) && $stable(stateQ)));

  // R6: a draining step reseeds
  p_reload_seed_r6: assert property (@(posedge clk) disable iff (rst)
    (strobes.stepWord && nextZero) |=> stateQ == INIT);

  // R6: register never all zeros outside reset
  p_never_zero_r6: assert property (@(posedge clk) disable iff (rst)
    strobes.stepWord |=> stateQ != '0);

endmodule

// File: rtl/prbs_gen.sv
module prbs_gen
  import prbs_pkg::*;
#(
  parameter int                 STATE_W = 31,
  parameter logic [STATE_W-1:0] POLY    = 31'h10000001,
  parameter logic [STATE_W-1:0] INIT    = '1,
  parameter logic               INVERT  = 1'b1,
  parameter int                 DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  output logic [DATA_W-1:0] dataOut
);

  prbsStrobes_t strobes;
  logic         nextZero;

  prbs_ctrl u_ctrl (
    .rst      (rst),
    .en       (en),
    .nextZero (nextZero),
    .strobes  (strobes)
  );

  prbs_datapath #(
    .STATE_W (STATE_W),
    .POLY    (POLY),
    .INIT    (INIT),
    .INVERT  (INVERT),
    .DATA_W  (DATA_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .nextZero (nextZero),
    .dataOut  (dataOut)
  );

endmodule

// File: tb/prbs_gen_tb.sv
`timescale 1ns/1ps
module prbs_gen_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [7:0]  d7;
  logic [15:0] d15;
  logic [2:0]  dz;

  prbs_gen #(.STATE_W(7), .POLY(7'h41), .INIT(7'h7f), .INVERT(1'b0), .DATA_W(8))
    u_dut (.clk(clk), .rst(rst), .en(en), .dataOut(d7));
  prbs_gen #(.STATE_W(15), .POLY(15'h4001), .INIT(15'h7fff), .INVERT(1'b1), .DATA_W(16))
    u_dut15 (.clk(clk), .rst(rst), .en(en), .dataOut(d15));
  prbs_gen #(.STATE_W(5), .POLY(5'h00), .INIT(5'b00101), .INVERT(1'b0), .DATA_W(3))
    u_dutZero (.clk(clk), .rst(rst), .en(en), .dataOut(dz));

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bit h7[$];
  bit h15[$];
  bit hz[$];
  bit s7[$];
  logic [63:0] e7, e15, ez;

  // history queue, oldest bit first
  task automatic seed(ref bit h[$], input int w, input logic [63:0] init);
    h.delete();
    for (int k = w - 1; k >= 0; k--) h.push_back(init[k]);
  endtask

  task automatic step(ref bit h[$], input int w, input logic [63:0] poly,
                      input logic [63:0] init, input int dw, input bit inv,
                      output logic [63:0] word);
    bit any;
    word = '0;
    for (int i = 0; i < dw; i++) begin
      bit b;
      b = 1'b0;
      for (int j = 0; j < w; j++) if (poly[j]) b ^= h[j];
      word[i] = h[0] ^ inv;
      void'(h.pop_front());
      h.push_back(b);
    end
    any = 1'b0;
    foreach (h[k]) any |= h[k];
    if (!any) seed(h, w, init);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    seed(h7, 7, 64'h7f);
    seed(h15, 15, 64'h7fff);
    seed(hz, 5, 64'b00101);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R4 reset d7", d7, 0);
    chk("R4 reset d15", d15, 0);
    chk("R4 reset dz", dz, 0);
    e7 = 0; e15 = 0; ez = 0;
    for (int cyc = 0; cyc < 700; cyc++) begin
      bit doRst;
      bit doEn;
      doRst = (cyc == 37);
      doEn  = ((cyc % 5 != 3) && (cyc % 11 != 0)) || doRst;
      rst = doRst;
      en  = doEn;
      if (doRst) begin
        seed(h7, 7, 64'h7f);
        seed(h15, 15, 64'h7fff);
        seed(hz, 5, 64'b00101);
        e7 = 0; e15 = 0; ez = 0;
        s7.delete();
      end else if (doEn) begin
        step(h7, 7, 64'h41, 64'h7f, 8, 1'b0, e7);
        step(h15, 15, 64'h4001, 64'h7fff, 16, 1'b1, e15);
        step(hz, 5, 64'h0, 64'b00101, 3, 1'b0, ez);
      end
      @(negedge clk);
      if (doRst) begin
        chk("R4 mid reset d7", d7, e7);
        chk("R4 mid reset d15", d15, e15);
      end else if (doEn) begin
        chk("R1 prbs7 word", d7, e7);
        chk("R5 prbs15 inverted word", d15, e15);
      end else begin
        chk("R3 hold d7", d7, e7);
        chk("R3 hold d15", d15, e15);
      end
      chk("R6 drain and reseed", dz, ez);
      if (!doRst && doEn) for (int i = 0; i < 8; i++) s7.push_back(d7[i]);
    end
    rst = 1'b0;
    en  = 1'b0;

    begin
      bit ser[$];
      int bad;
      int ones;
      bad = 0;
      for (int n = 0; n < s7.size(); n++) begin
        if (n < 7) ser.push_back(1'b1);
        else ser.push_back(ser[n-1] ^ ser[n-7]);
        if (s7[n] != ser[n]) bad++;
      end
      chk("R2 parallel vs serial mismatches", bad, 0);
      bad = 0;
      for (int i = 0; i + 127 < s7.size(); i++) if (s7[i] != s7[i+127]) bad++;
      chk("R7 period 127 mismatches", bad, 0);
      ones = 0;
      for (int i = 0; i < 127; i++) ones += int'(s7[i]);
      chk("R7 ones per period", ones, 64);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule